// File: doc/BRIEF.md
# Simple Serial Port with Single-Byte Buffers

This block is a serial port attached to a plain register bus. Software writes one byte to the data register; the block moves it into a shift register and sends it on `txd` as a fixed frame: one low start bit, eight data bits least significant bit first, and one high stop bit. There is no parity and no flow control. In the other direction, the block watches `rxd` for a falling edge and samples each bit halfway through its period. It keeps one received byte for software to collect.

Each direction holds exactly one byte. An event flag register records four conditions: transmit buffer freed, byte received, transmit overrun and receive overrun. Software clears a flag by writing a one to its bit. Three interrupt lines are driven from these flags through enables in the control register. One line is for transmit, one is for receive, and one is shared by both overrun conditions. The bit time is set by a 21-bit divider that counts clock cycles per serial bit.

The bus is a single-cycle port. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from the selected register. A read of the data register frees the receive buffer at that same edge. Registers are word aligned and selected by `bus_addr[4:2]`.

Top module: `sio_port`

## Requirements
- R1: After reset, the state (0x04), control (0x08) and flag (0x0C) registers read zero, the divider (0x10) reads 16, `txd` is high and all three interrupt lines are low.
- R2: A data write (0x00) with state bit 0 clear sets state bit 0 (transmit buffer full). With control bit 0 (transmit enable) set, the byte is then sent on `txd` as start low, eight data bits LSB first and stop high, each bit lasting the effective divider in clock cycles.
- R3: When the held byte moves into the shift register, state bit 0 clears and flag bit 0 sets. `irq_tx` equals flag bit 0 AND control bit 2.
- R4: A data write while state bit 0 is set sets flag bit 2 (transmit overrun, also seen as state bit 2), and the written byte is dropped. The held byte is the one that is sent.
- R5: A received frame with a high stop bit is stored, and state bit 1 and flag bit 1 are set. `irq_rx` equals flag bit 1 AND control bit 3. Reading the data register returns the byte in bits [7:0] and clears state bit 1.
- R6: A frame that completes while state bit 1 is set, and that is not read in the same cycle, sets flag bit 3 (receive overrun, also seen as state bit 3). The held byte is left unchanged.
- R7: A received frame whose stop bit samples low is discarded: state bit 1 and flag bit 1 stay clear.
- R8: Writing the flag register clears each flag whose bit is written as 1 and leaves flags written as 0 unchanged. A flag that is set in the same cycle stays set.
- R9: `irq_ovr` equals (flag bit 2 AND control bit 4) OR (flag bit 3 AND control bit 5).
- R10: Clearing control bit 0 lets a frame already on `txd` finish, and the held byte waits until the bit is set again. With control bit 1 clear, no new incoming frame is started.
- R11: The divider register keeps bits [20:0] of a write and reads zero above them. Stored values below 16 act as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address, bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| irq_tx | output | 1 | Transmit buffer freed interrupt |
| irq_rx | output | 1 | Byte received interrupt |
| irq_ovr | output | 1 | Either overrun interrupt |

## Verification
The hardest condition to reach from the ports is a second byte arriving while the first is still held. Both overrun paths depend on it, as does keeping a frame in flight when the transmitter is disabled mid-frame. The stimulus reaches it by holding transmit enable off while writing two bytes, and by sending two receive frames back to back without a read. For the mid-frame case, it clears the enable in a thread that runs in parallel with decoding a frame that is already on the line. Random bytes from a fixed seed are sent in both directions at two divider settings and at a clamped one. Each captured frame is decoded from the line at the middle of its bits.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int DIV_W   = 21;
    localparam int MIN_DIV = 16;
    localparam int ADDR_W  = 5;

    // register index = bus_addr[4:2]
    localparam logic [2:0] REG_DATA  = 3'd0;
    localparam logic [2:0] REG_STATE = 3'd1;
    localparam logic [2:0] REG_CTRL  = 3'd2;
    localparam logic [2:0] REG_FLAG  = 3'd3;
    localparam logic [2:0] REG_DIV   = 3'd4;

    // control bits
    localparam int CTL_TXEN  = 0;
    localparam int CTL_RXEN  = 1;
    localparam int CTL_TXIE  = 2;
    localparam int CTL_RXIE  = 3;
    localparam int CTL_TXOIE = 4;
    localparam int CTL_RXOIE = 5;

    // flag bits
    localparam int FLG_TX  = 0;
    localparam int FLG_RX  = 1;
    localparam int FLG_TXO = 2;
    localparam int FLG_RXO = 3;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_phase_e;

    typedef struct packed {
        logic [7:0]       tx_hold;
        logic             tx_full;
        logic [7:0]       rx_hold;
        logic             rx_full;
        logic [5:0]       ctrl;
        logic [3:0]       flags;
        logic [DIV_W-1:0] div;
    } regs_t;
endpackage

// File: rtl/sio_tx.sv
module sio_tx import sio_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             start_i,
    input  logic [7:0]       byte_i,
    output logic             busy_o,
    output logic             txd_o
);
    localparam int FRAME_BITS = 10;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                  active;
        logic [DIV_W-1:0]      cnt;
        logic [BIT_IDX_W-1:0]  bitn;
        logic [FRAME_BITS-1:0] sh;
    } tx_st_t;

    tx_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.sh     = {1'b1, byte_i, 1'b0};
                st_d.cnt    = div_i - DIV_W'(1);
                st_d.bitn   = '0;
            end
        end else if (st_q.cnt == '0) begin
            if (st_q.bitn == BIT_IDX_W'(FRAME_BITS - 1)) begin
                st_d.active = 1'b0;
                st_d.sh     = '1;
            end else begin
                st_d.sh   = {1'b1, st_q.sh[FRAME_BITS-1:1]};
                st_d.bitn = st_q.bitn + BIT_IDX_W'(1);
                st_d.cnt  = div_i - DIV_W'(1);
            end
        end else begin
            st_d.cnt = st_q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.sh     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.active;
    assign txd_o  = st_q.sh[0];
endmodule

// File: rtl/sio_rx.sv
module sio_rx import sio_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             en_i,
    input  logic             rxd_i,
    output logic             done_o,
    output logic [7:0]       byte_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        rx_phase_e              ph;
        logic [DIV_W-1:0]       cnt;
        logic [2:0]             bitn;
        logic [7:0]             sh;
        logic                   done;
    } rx_st_t;

    rx_st_t st_q, st_d;
    logic   line;

    assign line = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], rxd_i};
        st_d.prev = line;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            RX_IDLE: begin
                if (en_i && st_q.prev && !line) begin
                    st_d.ph  = RX_START;
                    st_d.cnt = (div_i >> 1) - DIV_W'(1);
                end
            end
            RX_START: begin
                if (st_q.cnt == '0) begin
                    if (!line) begin
                        st_d.ph   = RX_DATA;
                        st_d.cnt  = div_i - DIV_W'(1);
                        st_d.bitn = '0;
                    end else begin
                        st_d.ph = RX_IDLE;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - DIV_W'(1);
                end
            end
            RX_DATA: begin
                if (st_q.cnt == '0) begin
                    st_d.sh  = {line, st_q.sh[7:1]};
                    st_d.cnt = div_i - DIV_W'(1);
                    if (st_q.bitn == 3'd7) st_d.ph = RX_STOP;
                    else                   st_d.bitn = st_q.bitn + 3'd1;
                end else begin
                    st_d.cnt = st_q.cnt - DIV_W'(1);
                end
            end
            RX_STOP: begin
                if (st_q.cnt == '0) begin
                    st_d.done = line;
                    st_d.ph   = RX_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - DIV_W'(1);
                end
            end
            default: st_d.ph = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sync <= '1;
            st_q.prev <= 1'b1;
            st_q.ph   <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign byte_o = st_q.sh;
endmodule

// File: rtl/sio_port.sv
module sio_port import sio_pkg::*; #(
    parameter int DIV_RESET   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              txd,
    input  logic              rxd,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_ovr
);
    regs_t            regs_q, regs_d;
    logic [2:0]       widx;
    logic             wr_en, rd_data;
    logic             tx_busy, tx_start;
    logic             rx_done;
    logic [7:0]       rx_byte;
    logic [DIV_W-1:0] div_eff;

    assign widx     = bus_addr[4:2];
    assign wr_en    = bus_sel & bus_wr;
    assign rd_data  = bus_sel & ~bus_wr & (widx == REG_DATA);
    assign div_eff  = (regs_q.div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : regs_q.div;
    assign tx_start = regs_q.ctrl[CTL_TXEN] & regs_q.tx_full & ~tx_busy;

    sio_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_i   (div_eff),
        .start_i (tx_start),
        .byte_i  (regs_q.tx_hold),
        .busy_o  (tx_busy),
        .txd_o   (txd)
    );

    sio_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_eff),
        .en_i   (regs_q.ctrl[CTL_RXEN]),
        .rxd_i  (rxd),
        .done_o (rx_done),
        .byte_o (rx_byte)
    );

    always_comb begin
        regs_d = regs_q;
        // clears first, so that any set below wins
        if (wr_en && widx == REG_FLAG)
            regs_d.flags = regs_q.flags & ~bus_wdata[3:0];
        if (wr_en && widx == REG_CTRL)
            regs_d.ctrl = bus_wdata[5:0];
        if (wr_en && widx == REG_DIV)
            regs_d.div = bus_wdata[DIV_W-1:0];
        if (tx_start) begin
            regs_d.tx_full       = 1'b0;
            regs_d.flags[FLG_TX] = 1'b1;
        end
        if (wr_en && widx == REG_DATA) begin
            if (regs_q.tx_full) begin
                regs_d.flags[FLG_TXO] = 1'b1;
            end else begin
                regs_d.tx_hold = bus_wdata[7:0];
                regs_d.tx_full = 1'b1;
            end
        end
        if (rd_data)
            regs_d.rx_full = 1'b0;
        if (rx_done) begin
            if (regs_q.rx_full && !rd_data) begin
                regs_d.flags[FLG_RXO] = 1'b1;
            end else begin
                regs_d.rx_hold       = rx_byte;
                regs_d.rx_full       = 1'b1;
                regs_d.flags[FLG_RX] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.div <= DIV_W'(DIV_RESET);
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (widx)
            REG_DATA:  bus_rdata[7:0]       = regs_q.rx_hold;
            REG_STATE: bus_rdata[3:0]       = {regs_q.flags[FLG_RXO], regs_q.flags[FLG_TXO],
                                               regs_q.rx_full, regs_q.tx_full};
            REG_CTRL:  bus_rdata[5:0]       = regs_q.ctrl;
            REG_FLAG:  bus_rdata[3:0]       = regs_q.flags;
            REG_DIV:   bus_rdata[DIV_W-1:0] = regs_q.div;
            default:   bus_rdata            = '0;
        endcase
    end

    assign irq_tx  = regs_q.flags[FLG_TX] & regs_q.ctrl[CTL_TXIE];
    assign irq_rx  = regs_q.flags[FLG_RX] & regs_q.ctrl[CTL_RXIE];
    assign irq_ovr = (regs_q.flags[FLG_TXO] & regs_q.ctrl[CTL_TXOIE]) |
                     (regs_q.flags[FLG_RXO] & regs_q.ctrl[CTL_RXOIE]);

    // plain names for the bound checker
    logic       obs_tx_full, obs_rx_full, obs_tx_en;
    logic [3:0] obs_flags;
    logic       obs_data_wr;
    assign obs_tx_full = regs_q.tx_full;
    assign obs_rx_full = regs_q.rx_full;
    assign obs_tx_en   = regs_q.ctrl[CTL_TXEN];
    assign obs_flags   = regs_q.flags;
    assign obs_data_wr = wr_en & (widx == REG_DATA);
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic       tx_busy,
    input logic       tx_en,
    input logic       tx_full,
    input logic       rx_full,
    input logic [3:0] flags,
    input logic       data_wr,
    input logic       rx_done,
    input logic       rx_read,
    input logic       irq_ovr
);
    a_r1_txd_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    a_r3_flag_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> flags[0]);

    a_r4_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && tx_full) |=> flags[2]);

    a_r5_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_full) |=> (rx_full && flags[1]));

    a_r6_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_full && !rx_read) |=> flags[3]);

    a_r9_ovr_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovr |-> (flags[3:2] != 2'b00));

    a_r10_tx_held_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !tx_busy) |=> !tx_busy);
endmodule

bind sio_port sio_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .txd     (txd),
    .tx_busy (tx_busy),
    .tx_en   (obs_tx_en),
    .tx_full (obs_tx_full),
    .rx_full (obs_rx_full),
    .flags   (obs_flags),
    .data_wr (obs_data_wr),
    .rx_done (rx_done),
    .rx_read (rd_data),
    .irq_ovr (irq_ovr)
);

// File: tb/sim_sio_port.sv
module sim_sio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd;
    logic        rxd = 1'b1;
    logic        irq_tx, irq_rx, irq_ovr;

    int n_chk = 0;
    int n_fail = 0;
    int unsigned seed_init;

    localparam logic [4:0] A_DATA = 5'h00, A_STATE = 5'h04, A_CTRL = 5'h08,
                           A_FLAG = 5'h0C, A_DIV = 5'h10;

    always #5 clk = ~clk;

    sio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txd(txd), .rxd(rxd), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr)
    );

    function automatic logic [31:0] state_word(bit txf, bit rxf, bit txo, bit rxo);
        return {28'd0, rxo, txo, rxf, txf};
    endfunction

    function automatic logic [31:0] flag_word(bit ftx, bit frx, bit txo, bit rxo);
        return {28'd0, rxo, txo, frx, ftx};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic tx_capture(input int div, output logic [7:0] b, output logic frame_ok);
        int waitc = 0;
        while (txd !== 1'b0 && waitc < 5000) begin
            @(negedge clk);
            waitc++;
        end
        repeat (div / 2) @(negedge clk);
        frame_ok = (txd == 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (div) @(negedge clk);
            b[i] = txd;
        end
        repeat (div) @(negedge clk);
        frame_ok = frame_ok & txd;
        repeat (div / 2 + 2) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop, input int div);
        logic [9:0] fr;
        fr = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rxd = fr[i];
            repeat (div - 1) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  cap, b1, b2;
        logic        ok;
        int          lows;

        seed_init = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_read(A_STATE, rd); check("R1 state", rd, 32'h0);
        bus_read(A_CTRL, rd);  check("R1 ctrl", rd, 32'h0);
        bus_read(A_FLAG, rd);  check("R1 flags", rd, 32'h0);
        bus_read(A_DIV, rd);   check("R1 divider", rd, 32'd16);
        check("R1 txd idle", {31'd0, txd}, 32'd1);
        check("R1 irqs", {29'd0, irq_tx, irq_rx, irq_ovr}, 32'd0);

        // R2/R10: hold a byte with transmit disabled
        bus_write(A_CTRL, 32'h3E);
        bus_write(A_DATA, 32'hA5);
        bus_read(A_STATE, rd); check("R2 tx full", rd, state_word(1, 0, 0, 0));
        bus_read(A_FLAG, rd);  check("R10 no load while off", rd, 32'h0);
        check("R10 txd idle while off", {31'd0, txd}, 32'd1);
        bus_write(A_CTRL, 32'h3F);
        tx_capture(16, cap, ok);
        check("R2 byte", {24'd0, cap}, 32'hA5);
        check("R2 framing", {31'd0, ok}, 32'd1);
        bus_read(A_STATE, rd); check("R3 buffer freed", rd, state_word(0, 0, 0, 0));
        bus_read(A_FLAG, rd);  check("R3 flag", rd, flag_word(1, 0, 0, 0));
        check("R3 irq_tx", {31'd0, irq_tx}, 32'd1);
        bus_write(A_FLAG, 32'h0);
        bus_read(A_FLAG, rd);  check("R8 zero write keeps", rd, flag_word(1, 0, 0, 0));
        bus_write(A_FLAG, 32'h1);
        bus_read(A_FLAG, rd);  check("R8 w1c", rd, 32'h0);
        check("R3 irq_tx cleared", {31'd0, irq_tx}, 32'd0);

        // R2 random bytes
        for (int k = 0; k < 5; k++) begin
            b1 = 8'($urandom);
            bus_write(A_DATA, {24'd0, b1});
            tx_capture(16, cap, ok);
            check("R2 random byte", {24'd0, cap}, {24'd0, b1});
            check("R2 random framing", {31'd0, ok}, 32'd1);
        end
        bus_write(A_FLAG, 32'hF);

        // R3 interrupt gating
        bus_write(A_CTRL, 32'h3B);
        bus_write(A_DATA, 32'h3C);
        tx_capture(16, cap, ok);
        bus_read(A_FLAG, rd); check("R3 flag masked", rd, flag_word(1, 0, 0, 0));
        check("R3 irq_tx masked", {31'd0, irq_tx}, 32'd0);
        bus_write(A_CTRL, 32'h3F);
        #1 check("R3 irq_tx unmasked", {31'd0, irq_tx}, 32'd1);
        bus_write(A_FLAG, 32'h1);

        // R4/R9 transmit overrun
        bus_write(A_CTRL, 32'h3E);
        bus_write(A_DATA, 32'h11);
        bus_write(A_DATA, 32'h22);
        bus_read(A_STATE, rd); check("R4 state overrun", rd, state_word(1, 0, 1, 0));
        bus_read(A_FLAG, rd);  check("R4 flag overrun", rd, flag_word(0, 0, 1, 0));
        check("R9 irq_ovr on", {31'd0, irq_ovr}, 32'd1);
        bus_write(A_CTRL, 32'h2E);
        #1 check("R9 irq_ovr masked", {31'd0, irq_ovr}, 32'd0);
        bus_write(A_CTRL, 32'h3F);
        tx_capture(16, cap, ok);
        check("R4 held byte sent", {24'd0, cap}, 32'h11);
        bus_read(A_STATE, rd); check("R4 second dropped", rd, state_word(0, 0, 1, 0));
        bus_write(A_FLAG, 32'h5);
        bus_read(A_FLAG, rd);  check("R8 clear two", rd, 32'h0);

        // R10 disable during a frame
        bus_write(A_DATA, 32'h96);
        fork
            tx_capture(16, cap, ok);
            begin
                repeat (20) @(negedge clk);
                bus_write(A_CTRL, 32'h3E);
                bus_write(A_DATA, 32'h5A);
            end
        join
        check("R10 frame completes", {24'd0, cap}, 32'h96);
        check("R10 frame framing", {31'd0, ok}, 32'd1);
        lows = 0;
        for (int i = 0; i < 640; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        check("R10 no send while off", lows, 0);
        bus_read(A_STATE, rd); check("R10 byte waits", rd, state_word(1, 0, 0, 0));
        bus_write(A_CTRL, 32'h3F);
        tx_capture(16, cap, ok);
        check("R10 byte after enable", {24'd0, cap}, 32'h5A);
        bus_write(A_FLAG, 32'hF);

        // R5 receive random bytes
        for (int k = 0; k < 5; k++) begin
            b1 = 8'($urandom);
            send_frame(b1, 1'b1, 16);
            bus_read(A_STATE, rd); check("R5 rx full", rd, state_word(0, 1, 0, 0));
            bus_read(A_FLAG, rd);  check("R5 rx flag", rd, flag_word(0, 1, 0, 0));
            check("R5 irq_rx", {31'd0, irq_rx}, 32'd1);
            bus_read(A_DATA, rd);  check("R5 rx byte", rd, {24'd0, b1});
            bus_read(A_STATE, rd); check("R5 read frees", rd, state_word(0, 0, 0, 0));
            bus_write(A_FLAG, 32'h2);
        end
        bus_write(A_CTRL, 32'h37);
        send_frame(8'h81, 1'b1, 16);
        check("R5 irq_rx masked", {31'd0, irq_rx}, 32'd0);
        bus_read(A_DATA, rd);  check("R5 masked byte", rd, 32'h81);
        bus_write(A_FLAG, 32'hF);
        bus_write(A_CTRL, 32'h3F);

        // R6 receive overrun
        b1 = 8'($urandom);
        b2 = ~b1;
        send_frame(b1, 1'b1, 16);
        send_frame(b2, 1'b1, 16);
        bus_read(A_STATE, rd); check("R6 state", rd, state_word(0, 1, 0, 1));
        bus_read(A_FLAG, rd);  check("R6 flags", rd, flag_word(0, 1, 0, 1));
        check("R9 irq_ovr rx", {31'd0, irq_ovr}, 32'd1);
        bus_read(A_DATA, rd);  check("R6 first kept", rd, {24'd0, b1});
        bus_write(A_FLAG, 32'hF);

        // R7 bad stop bit
        send_frame(8'h5B, 1'b0, 16);
        repeat (16) @(negedge clk);
        bus_read(A_STATE, rd); check("R7 discarded state", rd, 32'h0);
        bus_read(A_FLAG, rd);  check("R7 discarded flags", rd, 32'h0);

        // R10 receive disabled
        bus_write(A_CTRL, 32'h3D);
        send_frame(8'h42, 1'b1, 16);
        bus_read(A_STATE, rd); check("R10 rx off", rd, 32'h0);
        bus_write(A_CTRL, 32'h3F);

        // R11 divider handling
        bus_write(A_DIV, 32'd3);
        bus_read(A_DIV, rd);   check("R11 small readback", rd, 32'd3);
        bus_write(A_DATA, 32'hC3);
        tx_capture(16, cap, ok);
        check("R11 clamped tx", {24'd0, cap}, 32'hC3);
        check("R11 clamped framing", {31'd0, ok}, 32'd1);
        send_frame(8'h2D, 1'b1, 16);
        bus_read(A_DATA, rd);  check("R11 clamped rx", rd, 32'h2D);
        bus_write(A_DIV, 32'hFFFF_FFFF);
        bus_read(A_DIV, rd);   check("R11 field width", rd, 32'h001F_FFFF);
        bus_write(A_DIV, 32'd20);
        bus_write(A_FLAG, 32'hF);
        for (int k = 0; k < 3; k++) begin
            b1 = 8'($urandom);
            bus_write(A_DATA, {24'd0, b1});
            tx_capture(20, cap, ok);
            check("R2 div20 tx", {24'd0, cap}, {24'd0, b1});
            check("R2 div20 framing", {31'd0, ok}, 32'd1);
            b2 = 8'($urandom);
            send_frame(b2, 1'b1, 20);
            bus_read(A_DATA, rd);  check("R5 div20 rx", rd, {24'd0, b2});
        end

        finish_run();
    end
endmodule